// File: doc/BRIEF.md
# Serial Slave Receiver with Word Buffer

This block receives 8-bit words from an external serial master while acting as a clocked serial slave. Software sets a transfer length, then arms each expected word by writing one dummy word to a transmit-data address. Armed words are shifted in on the master's clock and stored in a 16-entry buffer. When the last word of the programmed length lands, a one-cycle interrupt is raised and software drains the buffer in arrival order through a single receive-data address.

The serial clock and data inputs are brought into the system clock domain by a two-stage synchroniser, and the clock's rising edge is detected there. The block never drives data or chip selects: the serial output stays low and every chip-select output stays at its inactive (high) level. A sticky overrun flag records any word that completed while the buffer was full.

Register bus (3-bit address, 8-bit data, write and read strobes, combinational read data): 0 = control (bit 0 clock enable, bit 1 receive enable); 1 = length (bits 3:0); 2 = dummy transmit data; 3 = chip-select data (no effect); 4 = status (read: bit 7 overrun, bit 6 full, bit 5 empty, bits 3:0 write pointer; write: bit 0 = 1 clears pointers, bit 7 = 1 clears overrun); 5 = receive data (a read strobe pops one word).

Top module: `sslv_rx_buf`

## Requirements
- R1: After reset, control reads 0x00, length reads 0x00, status reads 0x20, and irq is low.
- R2: Writing status with bit 0 set zeroes the write and read pointers, fill level, armed and received counts; status then reads full 0, empty 1, pointer 0000.
- R3: While the clock-enable bit (control bit 0) is 0, writes to length, dummy data and status are ignored, and control bit 1 cannot be set.
- R4: The length field is 4 bits; a value of 0 means 16 words. Writing it starts a new transfer by zeroing the armed and received counts.
- R5: Each dummy-data write (address 2) accepted while receive enable is 1 arms one word; serial bits arriving while no armed word is pending are ignored.
- R6: Dummy writes beyond the programmed length are ignored.
- R7: Words are 8 bits, sampled MSB first on rising edges of the serial clock, stored in arrival order, and returned in that order by successive reads of address 5; the status write pointer advances by one per stored word.
- R8: irq is high for exactly one cycle when the word that completes the programmed length is received.
- R9: The status empty bit (bit 5) is 1 exactly when every armed word has been received.
- R10: Clearing receive enable (control bit 1) stops reception; with it set, further transfers run with a new length and new dummy writes.
- R11: A word that completes while the buffer holds 16 unread words is discarded and sets the overrun bit (status bit 7), which stays set until status is written with bit 7 set.
- R12: sdo is always 0 and all cs_n outputs are always 1; writes to address 3 change neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| sck | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data out, held low |
| cs_n | output | 4 | Chip-select outputs, held inactive high |
| irq | output | 1 | Transfer-complete pulse |

## Verification
Words are sent with alternating, complementary and all-ones bit patterns so that a reversed bit order or a dropped shift shows up as a wrong value. Serial traffic is also sent with nothing armed, with more dummy writes than the length allows, and with receive enable cleared, each of which must leave the write pointer where it was. A sixteen-word transfer with length 0 followed by one more word checks the 16-word encoding, pointer wrap, the full flag and the overrun path, and draining the buffer afterwards checks read order across the wrap.

// File: rtl/sslv_pkg.sv
package sslv_pkg;

    localparam int CNT_W        = 4;
    localparam int STAT_OVR_BIT = 7;
    localparam int STAT_FUL_BIT = 6;
    localparam int STAT_EMP_BIT = 5;
    localparam int STAT_CLR_BIT = 0;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_COUNT = 3'd1,
        REG_TXD   = 3'd2,
        REG_CSD   = 3'd3,
        REG_STAT  = 3'd4,
        REG_RXD   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic rx_en;
        logic clk_en;
    } ctrl_t;

    // Length field value 0 encodes the full 2**CNT_W words.
    function automatic logic [CNT_W:0] len_goal(input logic [CNT_W-1:0] len);
        return (len == '0) ? (CNT_W+1)'(1 << CNT_W) : {1'b0, len};
    endfunction

endpackage

// File: rtl/sslv_sync.sv
module sslv_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], din};
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/sslv_shift.sv
module sslv_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic              sck_s,
    input  logic              sdi_s,
    output logic              word_vld,
    output logic [DATA_W-1:0] word
);
    localparam int BC_W = $clog2(DATA_W);

    logic              sck_q;
    logic [BC_W-1:0]   bcnt;
    logic [DATA_W-2:0] sh;
    logic              take, last;

    assign take     = sck_s & ~sck_q & en;
    assign last     = (bcnt == BC_W'(DATA_W-1));
    assign word     = {sh, sdi_s};
    assign word_vld = take & last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            bcnt  <= '0;
            sh    <= '0;
        end else begin
            sck_q <= sck_s;
            if (clr) begin
                bcnt <= '0;
            end else if (take) begin
                sh   <= word[DATA_W-2:0];
                bcnt <= last ? '0 : bcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sslv_fifo.sv
module sslv_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     push,
    input  logic [DATA_W-1:0]        din,
    input  logic                     pop,
    output logic [DATA_W-1:0]        dout,
    output logic                     full,
    output logic [$clog2(DEPTH)-1:0] wptr
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int FILL_W = PTR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [FILL_W-1:0] fill;
    logic              do_push, do_pop;

    assign full    = (fill == FILL_W'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & (fill != '0);
    assign dout    = mem[rp];
    assign wptr    = wp;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            fill <= fill + FILL_W'(do_push) - FILL_W'(do_pop);
        end
    end
endmodule

// File: rtl/sslv_rx_buf.sv
module sslv_rx_buf
    import sslv_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 16,
    parameter int NUM_CS      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck,
    input  logic              sdi,
    output logic              sdo,
    output logic [NUM_CS-1:0] cs_n,
    output logic              irq
);
    localparam int PTR_W = $clog2(DEPTH);

    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W:0]    armed_q, recvd_q, goal;
    logic              ovr_q, irq_q;
    reg_sel_e          sel;
    logic              wr_ok, wr_cnt, wr_txd, wr_stat;
    logic              ptr_clr, ovr_clr, arm_ok, rx_open;
    logic [1:0]        sync_o;
    logic              word_vld, full, pop;
    logic [DATA_W-1:0] word, rx_dout;
    logic [PTR_W-1:0]  wptr;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_ok   = bus_wr & ctrl_q.clk_en;
    assign wr_cnt  = wr_ok & (sel == REG_COUNT);
    assign wr_txd  = wr_ok & (sel == REG_TXD) & ctrl_q.rx_en;
    assign wr_stat = wr_ok & (sel == REG_STAT);
    assign ptr_clr = wr_stat & bus_wdata[STAT_CLR_BIT];
    assign ovr_clr = wr_stat & bus_wdata[STAT_OVR_BIT];
    assign goal    = len_goal(len_q);
    assign arm_ok  = wr_txd & (armed_q < goal);
    assign rx_open = ctrl_q.rx_en & (recvd_q < armed_q);
    assign pop     = bus_rd & (sel == REG_RXD);

    sslv_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({sdi, sck}),
        .dout(sync_o)
    );

    sslv_shift #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .clr     (ptr_clr | ~ctrl_q.rx_en),
        .en      (rx_open),
        .sck_s   (sync_o[0]),
        .sdi_s   (sync_o[1]),
        .word_vld(word_vld),
        .word    (word)
    );

    sslv_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk (clk),
        .rst (rst),
        .clr (ptr_clr),
        .push(word_vld),
        .din (word),
        .pop (pop),
        .dout(rx_dout),
        .full(full),
        .wptr(wptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            len_q   <= '0;
            armed_q <= '0;
            recvd_q <= '0;
            ovr_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (bus_wr && sel == REG_CTRL) begin
                ctrl_q.clk_en <= bus_wdata[0];
                ctrl_q.rx_en  <= bus_wdata[1] & bus_wdata[0];
            end
            if (wr_cnt) len_q <= bus_wdata[CNT_W-1:0];
            if (ptr_clr || wr_cnt) armed_q <= '0;
            else if (arm_ok)       armed_q <= armed_q + 1'b1;
            if (ptr_clr || wr_cnt) recvd_q <= '0;
            else if (word_vld)     recvd_q <= recvd_q + 1'b1;
            if (word_vld && full)  ovr_q <= 1'b1;
            else if (ovr_clr)      ovr_q <= 1'b0;
            irq_q <= word_vld && ((recvd_q + 1'b1) == goal);
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_CTRL:  bus_rdata[1:0] = {ctrl_q.rx_en, ctrl_q.clk_en};
            REG_COUNT: bus_rdata[CNT_W-1:0] = len_q;
            REG_STAT: begin
                bus_rdata[STAT_OVR_BIT] = ovr_q;
                bus_rdata[STAT_FUL_BIT] = full;
                bus_rdata[STAT_EMP_BIT] = (armed_q == recvd_q);
                bus_rdata[PTR_W-1:0]    = wptr;
            end
            REG_RXD:   bus_rdata = rx_dout;
            default:   bus_rdata = '0;
        endcase
    end

    for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
        assign cs_n[c] = 1'b1;
    end

    assign sdo = 1'b0;
    assign irq = irq_q;
endmodule

// File: rtl/sslv_rx_chk.sv
module sslv_rx_chk #(
    parameter int CNT_W  = 4,
    parameter int PTR_W  = 4,
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sdo,
    input logic [NUM_CS-1:0] cs_n,
    input logic              irq,
    input logic [CNT_W:0]    armed,
    input logic [CNT_W:0]    recvd,
    input logic [CNT_W:0]    goal,
    input logic              word_vld,
    input logic              full,
    input logic              ptr_clr,
    input logic              ovr,
    input logic              ovr_clr,
    input logic [PTR_W-1:0]  wptr
);
    a_r12_sdo_low: assert property (@(posedge clk) disable iff (rst) sdo == 1'b0);
    a_r12_cs_idle: assert property (@(posedge clk) disable iff (rst) cs_n == '1);
    a_r8_irq_single: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);
    a_r6_arm_limit: assert property (@(posedge clk) disable iff (rst) armed <= goal);
    a_r5_recv_armed: assert property (@(posedge clk) disable iff (rst) recvd <= armed);
    a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr) |=> ovr);
    a_r11_full_no_store: assert property (@(posedge clk) disable iff (rst)
        (word_vld && full && !ptr_clr) |=> $stable(wptr));
endmodule

bind sslv_rx_buf sslv_rx_chk #(.CNT_W(sslv_pkg::CNT_W), .PTR_W(PTR_W), .NUM_CS(NUM_CS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sdo     (sdo),
    .cs_n    (cs_n),
    .irq     (irq),
    .armed   (armed_q),
    .recvd   (recvd_q),
    .goal    (goal),
    .word_vld(word_vld),
    .full    (full),
    .ptr_clr (ptr_clr),
    .ovr     (ovr_q),
    .ovr_clr (ovr_clr),
    .wptr    (wptr)
);

// File: tb/test_sslv_rx_buf.sv
`timescale 1ns/100ps
module test_sslv_rx_buf;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sck = 1'b0, sdi = 1'b0;
    logic       sdo, irq;
    logic [3:0] cs_n;

    int checks = 0, fails = 0, irq_seen = 0, irq_exp = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit         m_clk = 0, m_rx = 0, m_ovr = 0;
    int         m_len = 0, m_armed = 0, m_recvd = 0, m_wr = 0;
    logic [7:0] m_q[$];

    always #2.5 clk = ~clk;

    sslv_rx_buf i_sslv_rx_buf (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .sdi(sdi),
        .sdo(sdo), .cs_n(cs_n), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every-clock comparison of the idle outputs and the interrupt pulse width
    logic irq_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R12 sdo", {7'd0, sdo}, 8'h00);
            chk("R12 cs_n", {4'd0, cs_n}, 8'h0F);
            if (irq && irq_prev) chk("R8 irq width", 8'd2, 8'd1);
            if (irq) irq_seen++;
            irq_prev = irq;
        end
    end

    function automatic logic [7:0] exp_stat();
        int goal = (m_len == 0) ? 16 : m_len;
        logic [7:0] s = '0;
        s[7] = m_ovr;
        s[6] = (m_q.size() == 16);
        s[5] = (m_armed == m_recvd);
        s[3:0] = 4'(m_wr);
        if (goal < 0) s = '1;
        return s;
    endfunction

    task automatic bwrite(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [2:0] a, input bit popit, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = popit;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic m_ctrl(input logic [7:0] d);
        bwrite(3'd0, d);
        m_clk = d[0]; m_rx = d[1] & d[0];
    endtask

    task automatic m_count(input logic [3:0] c);
        bwrite(3'd1, {4'd0, c});
        if (m_clk) begin m_len = c; m_armed = 0; m_recvd = 0; end
    endtask

    task automatic m_dummy();
        int goal = (m_len == 0) ? 16 : m_len;
        bwrite(3'd2, 8'h00);
        if (m_clk && m_rx && m_armed < goal) m_armed++;
    endtask

    task automatic m_stat_wr(input logic [7:0] d);
        bwrite(3'd4, d);
        if (m_clk && d[0]) begin m_wr = 0; m_armed = 0; m_recvd = 0; m_q.delete(); end
        if (m_clk && d[7]) m_ovr = 0;
    endtask

    task automatic send(input logic [7:0] w);
        int goal = (m_len == 0) ? 16 : m_len;
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk); sck = 1'b0; sdi = w[b];
            repeat (3) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        if (m_rx && m_recvd < m_armed) begin
            m_recvd++;
            if (m_q.size() == 16) m_ovr = 1;
            else begin m_q.push_back(w); m_wr = (m_wr + 1) % 16; end
            if (m_recvd == goal) irq_exp++;
        end
    endtask

    task automatic chk_stat(input string req);
        logic [7:0] d;
        bread(3'd4, 1'b0, d);
        chk(req, d, exp_stat());
    endtask

    task automatic drain(input string req);
        logic [7:0] d;
        while (m_q.size() > 0) begin
            bread(3'd5, 1'b1, d);
            chk(req, d, m_q.pop_front());
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        bread(3'd0, 1'b0, d); chk("R1 ctrl", d, 8'h00);
        bread(3'd1, 1'b0, d); chk("R1 length", d, 8'h00);
        chk_stat("R1 status");
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R3 writes ignored while clock enable is off
        m_count(4'd3);
        bread(3'd1, 1'b0, d); chk("R3 length gated", d, 8'h00);
        bwrite(3'd0, 8'h02);
        bread(3'd0, 1'b0, d); chk("R3 rx_en gated", d, 8'h00);
        m_dummy();
        chk_stat("R3 dummy gated");

        // R2 pointer clear
        m_ctrl(8'h03);
        bread(3'd0, 1'b0, d); chk("R10 ctrl enabled", d, 8'h03);
        m_stat_wr(8'h01);
        chk_stat("R2 pointer clear");

        // R5 bits with nothing armed are ignored
        send(8'hA5);
        chk_stat("R5 unarmed ignored");

        // R6 excess dummy, R7 order, R8 irq, R9 empty
        m_count(4'd2);
        m_dummy(); m_dummy(); m_dummy();
        chk_stat("R9 empty clear while pending");
        send(8'h3C); send(8'hC3); send(8'hFF);
        chk_stat("R6 excess dummy ignored");
        chk("R8 irq count", 8'(irq_seen), 8'(irq_exp));
        drain("R7 read order");

        // R10 repeated transfer
        m_count(4'd1); m_dummy();
        send(8'h81);
        chk("R10 second irq", 8'(irq_seen), 8'(irq_exp));
        drain("R10 second word");

        // R10 receive disable stops reception
        m_count(4'd1); m_dummy();
        m_ctrl(8'h01);
        send(8'h66);
        chk_stat("R10 disabled no store");
        m_ctrl(8'h03);
        m_stat_wr(8'h01);

        // R4 length 0 = 16 words, R11 overrun
        m_count(4'd0);
        for (int i = 0; i < 17; i++) m_dummy();
        for (int i = 0; i < 16; i++) send(8'(i * 37 + 5));
        chk_stat("R4 sixteen words full");
        chk("R4 irq", 8'(irq_seen), 8'(irq_exp));
        m_count(4'd1); m_dummy();
        send(8'h5A);
        chk_stat("R11 overrun set");
        drain("R7 wrap order");
        chk_stat("R11 overrun sticky");
        m_stat_wr(8'h80);
        chk_stat("R11 overrun cleared");

        // R12 chip-select data has no effect
        bwrite(3'd3, 8'h00);
        chk("R12 cs after write", {4'd0, cs_n}, 8'h0F);
        chk("R8 final irq count", 8'(irq_seen), 8'(irq_exp));

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule